// File: doc/BRIEF.md
# Chained-State Byte Scrambler

This block obscures a byte stream by passing each byte through a fixed run of XOR, add and subtract steps. The steps are mixed with two 8-bit chaining registers, so every output byte depends on the bytes before it in the same message. There are two independent lanes. The scramble lane turns plain bytes into coded bytes, and the unscramble lane turns coded bytes back into plain bytes. The lanes share no state, so outbound and inbound traffic can be handled in the same cycle.

Each lane takes one byte per accepted transfer on a valid/ready stream and returns one byte on a registered output stream. The first byte of a message is marked with a start flag. That byte is processed with both chaining registers freshly seeded, and the chain then continues from it. Messages are expected to be no longer than 64 bytes. The block does not count bytes, and the chain keeps running if a message is longer.

Top module: `chain_scrambler`

## Requirements
- R1: During and after reset both output valids are low and both input readies are high.
- R2: A byte accepted with its start flag high is processed with register A seeded to 0x9B and register B seeded to 0x54, whatever came before it. This holds in both lanes.
- R3: The scramble lane outputs c = (((u XOR A XOR 0x5A) - 0xB0) XOR 0x38) - 0x45, where u = (((p XOR B XOR 0x2B) - 0x05) XOR 0x35) - 0x39. All arithmetic is modulo 256. Afterwards A holds p and B holds c.
- R4: The unscramble lane outputs p = (((u + 0x39) XOR 0x35) + 0x05) XOR 0x2B XOR B, where u = (((c + 0x45) XOR 0x38) + 0xB0) XOR 0x5A XOR A. Afterwards A holds p and B holds c.
- R5: A byte accepted at a clock edge appears on the output with valid high immediately after that edge. If the output is taken and no new byte is accepted, valid drops after the next edge.
- R6: While output valid is high and output ready is low, the output byte holds, input ready is low and the chain does not advance.
- R7: Cycles with input valid low leave the chain unchanged, including when the start flag is high in those cycles.
- R8: A start flag in the middle of a stream restarts the chain from the seeds.
- R9: Activity in one lane, including a restart, has no effect on the other lane's chain.
- R10: Feeding the scramble lane's output for a message into the unscramble lane returns the original bytes in order. This holds for message lengths from 1 to 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| encInValid | input | 1 | Scramble lane: input byte valid |
| encInReady | output | 1 | Scramble lane: input can be accepted |
| encInStart | input | 1 | Scramble lane: byte opens a message |
| encInData | input | 8 | Scramble lane: plain byte |
| encOutValid | output | 1 | Scramble lane: output byte valid |
| encOutReady | input | 1 | Scramble lane: consumer takes output |
| encOutData | output | 8 | Scramble lane: coded byte |
| decInValid | input | 1 | Unscramble lane: input byte valid |
| decInReady | output | 1 | Unscramble lane: input can be accepted |
| decInStart | input | 1 | Unscramble lane: byte opens a message |
| decInData | input | 8 | Unscramble lane: coded byte |
| decOutValid | output | 1 | Unscramble lane: output byte valid |
| decOutReady | input | 1 | Unscramble lane: consumer takes output |
| decOutData | output | 8 | Unscramble lane: recovered plain byte |

## Verification
Each output byte depends on both chaining registers at once. A wrong or stale value in either register therefore shows up in the very next output byte, one cycle after that byte is accepted. The error also spreads to the bytes after it until the next start flag. The state problems most likely to escape are a chain that advances on a stalled or idle cycle, a start flag honoured without valid, and a restart that leaks into the other lane. The tests interleave stalls, idle cycles and restarts with known byte sequences, so that any of these shows as a byte mismatch on the following transfer. Handshake errors, such as a valid that does not drop or a ready that ignores backpressure, show in the same cycle at the stream ports.

// File: rtl/chain_scrambler_pkg.sv
package chain_scrambler_pkg;
  localparam int ByteW = 8;
  typedef logic [ByteW-1:0] byte_t;

  typedef struct packed {
    logic accept;   // byte taken this cycle
    logic restart;  // taken byte opens a message
  } laneStrb_t;

  // forward transform, state A then B
  function automatic byte_t scrambleStep(byte_t p, byte_t a, byte_t b);
    byte_t u;
    u = (((p ^ b ^ 8'h2B) - 8'h05) ^ 8'h35) - 8'h39;
    return (((u ^ a ^ 8'h5A) - 8'hB0) ^ 8'h38) - 8'h45;
  endfunction

  // inverse transform
  function automatic byte_t unscrambleStep(byte_t c, byte_t a, byte_t b);
    byte_t u;
    u = ((((c + 8'h45) ^ 8'h38) + 8'hB0) ^ 8'h5A) ^ a;
    return ((((u + 8'h39) ^ 8'h35) + 8'h05) ^ 8'h2B) ^ b;
  endfunction
endpackage

// File: rtl/chain_scrambler_ctrl.sv
module chain_scrambler_ctrl
  import chain_scrambler_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inStart,
  output logic      inReady,
  output logic      outValid,
  input  logic      outReady,
  output laneStrb_t strb
);
  logic validQ;

  assign inReady      = !validQ || outReady;
  assign strb.accept  = inValid && inReady;
  assign strb.restart = inValid && inReady && inStart;
  assign outValid     = validQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (strb.accept) begin
      validQ <= 1'b1;
    end else if (outReady) begin
      validQ <= 1'b0;
    end
  end
endmodule

// File: rtl/chain_scrambler_dp.sv
module chain_scrambler_dp
  import chain_scrambler_pkg::*;
#(
  parameter bit    Inverse = 1'b0,
  parameter byte_t SeedA   = 8'h9B,
  parameter byte_t SeedB   = 8'h54
) (
  input  logic      clk,
  input  logic      rstN,
  input  laneStrb_t strb,
  input  byte_t     inData,
  output byte_t     outData
);
  byte_t chainA, chainB;
  byte_t useA, useB;
  byte_t result;
  byte_t nextA, nextB;

  assign useA = strb.restart ? SeedA : chainA;
  assign useB = strb.restart ? SeedB : chainB;

  generate
    if (Inverse) begin : g_unscr
      assign result = unscrambleStep(inData, useA, useB);
      assign nextA  = result;
      assign nextB  = inData;
    end else begin : g_scr
      assign result = scrambleStep(inData, useA, useB);
      assign nextA  = inData;
      assign nextB  = result;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chainA  <= SeedA;
      chainB  <= SeedB;
      outData <= '0;
    end else if (strb.accept) begin
      chainA  <= nextA;
      chainB  <= nextB;
      outData <= result;
    end
  end
endmodule

// File: rtl/chain_scrambler.sv
module chain_scrambler
  import chain_scrambler_pkg::*;
#(
  parameter byte_t SeedA = 8'h9B,
  parameter byte_t SeedB = 8'h54
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       encInValid,
  output logic       encInReady,
  input  logic       encInStart,
  input  logic [7:0] encInData,
  output logic       encOutValid,
  input  logic       encOutReady,
  output logic [7:0] encOutData,
  input  logic       decInValid,
  output logic       decInReady,
  input  logic       decInStart,
  input  logic [7:0] decInData,
  output logic       decOutValid,
  input  logic       decOutReady,
  output logic [7:0] decOutData
);
  laneStrb_t encStrb, decStrb;

  chain_scrambler_ctrl u_encCtrl (
    .clk(clk), .rstN(rstN), .inValid(encInValid), .inStart(encInStart),
    .inReady(encInReady), .outValid(encOutValid), .outReady(encOutReady),
    .strb(encStrb)
  );
  chain_scrambler_dp #(.Inverse(1'b0), .SeedA(SeedA), .SeedB(SeedB)) u_encDp (
    .clk(clk), .rstN(rstN), .strb(encStrb), .inData(encInData),
    .outData(encOutData)
  );

  chain_scrambler_ctrl u_decCtrl (
    .clk(clk), .rstN(rstN), .inValid(decInValid), .inStart(decInStart),
    .inReady(decInReady), .outValid(decOutValid), .outReady(decOutReady),
    .strb(decStrb)
  );
  chain_scrambler_dp #(.Inverse(1'b1), .SeedA(SeedA), .SeedB(SeedB)) u_decDp (
    .clk(clk), .rstN(rstN), .strb(decStrb), .inData(decInData),
    .outData(decOutData)
  );
endmodule

// File: rtl/chain_scrambler_chk.sv
module chain_scrambler_chk (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inReady,
  input logic       outValid,
  input logic       outReady,
  input logic [7:0] outData
);
  // R6: a held output keeps its byte and its valid
  p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R6: no input is taken while the output is blocked
  p_block_input_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  // R5: an accepted byte is valid on the output after the edge
  p_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  // R5: a drained output with nothing new goes idle
  p_drain_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !inValid) |=> !outValid);

  // R1: an empty lane never refuses input
  p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);
endmodule

bind chain_scrambler chain_scrambler_chk u_chkEnc (
  .clk(clk), .rstN(rstN), .inValid(encInValid), .inReady(encInReady),
  .outValid(encOutValid), .outReady(encOutReady), .outData(encOutData)
);

bind chain_scrambler chain_scrambler_chk u_chkDec (
  .clk(clk), .rstN(rstN), .inValid(decInValid), .inReady(decInReady),
  .outValid(decOutValid), .outReady(decOutReady), .outData(decOutData)
);

// File: tb/chain_scrambler_bench.sv
`timescale 1ns/1ps
module chain_scrambler_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic encInValid = 0, encInStart = 0, encOutReady = 1;
  logic decInValid = 0, decInStart = 0, decOutReady = 1;
  logic [7:0] encInData = 0, decInData = 0;
  logic encInReady, encOutValid, decInReady, decOutValid;
  logic [7:0] encOutData, decOutData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench-side reference chains
  logic [7:0] eA, eB, dA, dB;

  always #4 clk = ~clk;

  chain_scrambler u_chain_scrambler (
    .clk(clk), .rstN(rstN),
    .encInValid(encInValid), .encInReady(encInReady), .encInStart(encInStart),
    .encInData(encInData), .encOutValid(encOutValid), .encOutReady(encOutReady),
    .encOutData(encOutData),
    .decInValid(decInValid), .decInReady(decInReady), .decInStart(decInStart),
    .decInData(decInData), .decOutValid(decOutValid), .decOutReady(decOutReady),
    .decOutData(decOutData)
  );

  function automatic logic [7:0] refScr(input logic [7:0] p, inout logic [7:0] a,
                                        inout logic [7:0] b);
    logic [7:0] u, c;
    u = (((p ^ b ^ 8'h2B) - 8'h05) ^ 8'h35) - 8'h39;
    c = (((u ^ a ^ 8'h5A) - 8'hB0) ^ 8'h38) - 8'h45;
    a = p;
    b = c;
    return c;
  endfunction

  function automatic logic [7:0] refUnscr(input logic [7:0] c, inout logic [7:0] a,
                                          inout logic [7:0] b);
    logic [7:0] u, p;
    u = ((((c + 8'h45) ^ 8'h38) + 8'hB0) ^ 8'h5A) ^ a;
    p = ((((u + 8'h39) ^ 8'h35) + 8'h05) ^ 8'h2B) ^ b;
    a = p;
    b = c;
    return p;
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one scramble byte; leaves the bench at a falling edge with the result on the port
  task automatic encOne(input logic [7:0] p, input logic st, input string tag,
                        output logic [7:0] got);
    logic [7:0] exp;
    encInValid = 1; encInData = p; encInStart = st;
    @(negedge clk);
    if (st) begin eA = 8'h9B; eB = 8'h54; end
    exp = refScr(p, eA, eB);
    check8({tag, " valid"}, {7'd0, encOutValid}, 8'd1);
    check8(tag, encOutData, exp);
    got = encOutData;
    encInValid = 0; encInStart = 0;
  endtask

  task automatic decOne(input logic [7:0] c, input logic st, input string tag,
                        input logic [7:0] expPlain);
    decInValid = 1; decInData = c; decInStart = st;
    @(negedge clk);
    check8({tag, " valid"}, {7'd0, decOutValid}, 8'd1);
    check8(tag, decOutData, expPlain);
    decInValid = 0; decInStart = 0;
  endtask

  task automatic t_reset;
    rstN = 0;
    repeat (3) @(negedge clk);
    check8("R1 enc valid in reset", {7'd0, encOutValid}, 8'd0);
    check8("R1 dec ready in reset", {7'd0, decInReady}, 8'd1);
    rstN = 1;
    @(negedge clk);
    check8("R1 enc ready", {7'd0, encInReady}, 8'd1);
    check8("R1 dec valid", {7'd0, decOutValid}, 8'd0);
  endtask

  task automatic t_seed;
    logic [7:0] g;
    // R2: known first byte: 0x00 with fresh seeds
    encOne(8'h00, 1'b1, "R2 seeded first byte", g);
    @(negedge clk);
    check8("R5 valid drops after drain", {7'd0, encOutValid}, 8'd0);
  endtask

  task automatic t_chain;
    logic [7:0] g;
    encOne(8'h41, 1'b1, "R3 chain byte0", g);
    encOne(8'hC3, 1'b0, "R3 chain byte1 back-to-back", g);
    @(negedge clk);
    encOne(8'h7E, 1'b0, "R3 chain byte2", g);
    encOne(8'hFF, 1'b0, "R3 chain byte3", g);
    @(negedge clk);
  endtask

  task automatic t_decode;
    logic [7:0] ca, cb, c;
    logic [7:0] pl [4];
    pl[0] = 8'h10; pl[1] = 8'hA5; pl[2] = 8'h00; pl[3] = 8'h99;
    ca = 8'h9B; cb = 8'h54;
    dA = 8'h9B; dB = 8'h54;
    for (int i = 0; i < 4; i++) begin
      c = refScr(pl[i], ca, cb);
      decOne(c, (i == 0), "R4 decode byte", refUnscr(c, dA, dB));
    end
    @(negedge clk);
  endtask

  task automatic t_restart;
    logic [7:0] g;
    encOne(8'h12, 1'b1, "R8 pre byte0", g);
    encOne(8'h34, 1'b0, "R8 pre byte1", g);
    encOne(8'h12, 1'b1, "R8 restart byte", g);
    encOne(8'h56, 1'b0, "R8 after restart", g);
    @(negedge clk);
  endtask

  task automatic t_stall;
    logic [7:0] g, held, exp2;
    encOutReady = 0;
    encOne(8'h5A, 1'b1, "R6 first under stall", g);
    held = g;
    encInValid = 1; encInData = 8'hA7; encInStart = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check8("R6 ready low in stall", {7'd0, encInReady}, 8'd0);
      check8("R6 output held", encOutData, held);
    end
    encOutReady = 1;
    @(negedge clk);
    exp2 = refScr(8'hA7, eA, eB);
    check8("R6 chain after stall", encOutData, exp2);
    encInValid = 0;
    @(negedge clk);
  endtask

  task automatic t_idle;
    logic [7:0] g;
    encOne(8'h01, 1'b1, "R7 before idle", g);
    encInValid = 0; encInStart = 1;
    for (int i = 0; i < 4; i++) begin
      encInData = 8'hF0 + 8'(i);
      @(negedge clk);
    end
    check8("R7 idle no output", {7'd0, encOutValid}, 8'd0);
    encOne(8'h02, 1'b0, "R7 chain kept over idle", g);
    @(negedge clk);
  endtask

  task automatic t_parallel;
    logic [7:0] c0, ca, cb;
    encOne(8'h21, 1'b1, "R9 enc byte0", c0);
    @(negedge clk);
    ca = 8'h9B; cb = 8'h54;
    dA = 8'h9B; dB = 8'h54;
    c0 = refScr(8'h77, ca, cb);
    // both lanes in the same cycle, the unscramble lane restarting
    encInValid = 1; encInData = 8'h22; encInStart = 0;
    decInValid = 1; decInData = c0; decInStart = 1;
    @(negedge clk);
    check8("R9 enc not restarted by dec", encOutData, refScr(8'h22, eA, eB));
    check8("R9 dec in parallel", decOutData, 8'h77);
    encInValid = 0; decInValid = 0; decInStart = 0;
    @(negedge clk);
  endtask

  task automatic t_roundtrip;
    logic [7:0] msg [64];
    logic [7:0] cod [64];
    int len;
    logic [7:0] g;
    for (int m = 0; m < 12; m++) begin
      len = (m == 0) ? 1 : (m == 1) ? 64 : 1 + int'($urandom_range(63));
      for (int i = 0; i < len; i++) msg[i] = 8'($urandom);
      for (int i = 0; i < len; i++) begin
        encOne(msg[i], (i == 0), "R10 encode pass", g);
        cod[i] = g;
      end
      @(negedge clk);
      for (int i = 0; i < len; i++) decOne(cod[i], (i == 0), "R10 round trip", msg[i]);
      @(negedge clk);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_seed;
    t_chain;
    t_decode;
    t_restart;
    t_stall;
    t_idle;
    t_parallel;
    t_roundtrip;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule